// File: doc/BRIEF.md
# Flow-Through SEC-DED Memory Error Corrector

This block guards a 16-bit memory data path with a single-error-correcting, double-error-detecting code. On the write side it turns the outgoing data word into check bits that are stored next to the word. On the read side it takes the stored word and its stored check bits and recomputes the check bits from the word. The XOR of the two is the syndrome. From the syndrome it drives two active-low flags and, when correction is enabled, a repaired data word. There is no clock anywhere in the block: every output follows its inputs combinationally.

A static width-select input picks one of two code sizes. With the input low, the code uses 8 check bits and an 8-bit syndrome. With it high, the code uses 6 check bits and a 6-bit syndrome, and the two upper bits of every check and syndrome bus are zero. Every data bit owns a distinct column of exactly three ones. Every check bit owns a column of exactly one one. A syndrome of even weight, or one of odd weight that matches no column, therefore signals an error that cannot be repaired.

Top module: `edac16_flow`

## Requirements
- R1: For data bit i, column i is the i-th smallest value (counting from 0) with exactly three ones and a width equal to the active code width. In 6-bit mode the columns of data bits 2 and 9 are swapped. `chk_gen_o` is the XOR of the columns of all set bits of `wr_data_i`.
- R2: With `narrow_mode_i` high, bits [7:6] of `chk_gen_o` and `syndrome_o` are 0. With it low, all 8 bits take part in the code.
- R3: The syndrome is the XOR of the check bits recomputed from `rd_data_i` and `rd_chk_i`. When it is zero, both `cerr_n_o` and `ncerr_n_o` are 1 and `rd_data_o` equals `rd_data_i`.
- R4: When exactly one data bit read back is wrong, `syndrome_o` equals that bit's column, `cerr_n_o` is 0 and `ncerr_n_o` is 1.
- R5: With `corr_en_i` high, the data bit whose column equals the syndrome is inverted on `rd_data_o`.
- R6: With `corr_en_i` low, `rd_data_o` equals `rd_data_i` for every syndrome.
- R7: When exactly one check bit is wrong, the syndrome has a single one at that bit's position, `cerr_n_o` is 0, `ncerr_n_o` is 1 and `rd_data_o` equals `rd_data_i`.
- R8: Any other nonzero syndrome, which includes every double error, drives `ncerr_n_o` to 0 and keeps `cerr_n_o` at 1. No data bit is inverted.
- R9: In 6-bit mode, an error on data bit 2 alone gives syndrome 8'h1C, which is bits 2, 3 and 4.
- R10: In 6-bit mode, bits [7:6] of `rd_chk_i` have no effect on any output.
- R11: All outputs settle within the same cycle that the inputs change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data_i | input | 16 | Data word being written |
| chk_gen_o | output | 8 | Check bits generated for `wr_data_i` |
| rd_data_i | input | 16 | Data word read from memory |
| rd_chk_i | input | 8 | Check bits read from memory |
| corr_en_i | input | 1 | High enables correction of a single data-bit error |
| narrow_mode_i | input | 1 | Low selects 8-bit code, high selects 6-bit code |
| rd_data_o | output | 16 | Read data, corrected when enabled |
| syndrome_o | output | 8 | Syndrome of the read word |
| cerr_n_o | output | 1 | Low on a correctable (single-bit) error |
| ncerr_n_o | output | 1 | Low on an uncorrectable error |

## Verification
The bench builds the block with its default parameters: 16 data bits, an 8-bit wide code and a 6-bit narrow code. This setting puts both code widths within reach of one run, including the pinned column of bit 2 and the swap it forces in the narrow table. For random words in both modes, the bench injects every single data-bit and check-bit error and a sample of double errors, with correction switched on and off. It also drives garbage onto the unused upper check lines in narrow mode to show that they are ignored.

// File: rtl/edac16_pkg.sv
package edac16_pkg;
  // In the narrow code, data bit 2 must own bits {2,3,4}. That value is
  // slot 9 of the ascending weight-3 list, so slots 2 and 9 trade places.
  localparam int unsigned PIN_BIT  = 2;
  localparam int unsigned PIN_SLOT = 9;

  // n-th smallest value with exactly three ones among width-bit values
  function automatic int unsigned nth_weight3(int unsigned n, int unsigned width);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    for (int unsigned v = 0; v < (32'd1 << width); v++) begin
      if ($countones(v) == 3) begin
        if (cnt == n) res = v;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic int unsigned narrow_slot(int unsigned bit_idx);
    if (bit_idx == PIN_BIT) return PIN_SLOT;
    if (bit_idx == PIN_SLOT) return PIN_BIT;
    return bit_idx;
  endfunction

  typedef enum logic [1:0] {
    SYN_CLEAN   = 2'd0,
    SYN_CHK_BIT = 2'd1,
    SYN_DATA    = 2'd2,
    SYN_UNCORR  = 2'd3
  } syn_class_e;
endpackage

// File: rtl/edac16_col_rom.sv
module edac16_col_rom #(
  parameter int DATA_W   = 16,
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 6
) (
  input  logic                          narrow_i,
  output logic [DATA_W-1:0][WIDE_W-1:0] cols_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam int unsigned WIDE_V   = edac16_pkg::nth_weight3(i, WIDE_W);
    localparam int unsigned NARROW_V =
      edac16_pkg::nth_weight3(edac16_pkg::narrow_slot(i), NARROW_W);
    localparam logic [WIDE_W-1:0] COL_W = WIDE_V[WIDE_W-1:0];
    localparam logic [WIDE_W-1:0] COL_N = NARROW_V[WIDE_W-1:0];
    assign cols_o[i] = narrow_i ? COL_N : COL_W;
  end
endmodule

// File: rtl/edac16_chk_gen.sv
module edac16_chk_gen #(
  parameter int DATA_W = 16,
  parameter int WIDE_W = 8
) (
  input  logic [DATA_W-1:0]             data_i,
  input  logic [DATA_W-1:0][WIDE_W-1:0] cols_i,
  output logic [WIDE_W-1:0]             chk_o
);
  always_comb begin
    chk_o = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (data_i[i]) chk_o = chk_o ^ cols_i[i];
    end
  end
endmodule

// File: rtl/edac16_syn_decode.sv
module edac16_syn_decode #(
  parameter int DATA_W = 16,
  parameter int WIDE_W = 8
) (
  input  logic [WIDE_W-1:0]             syn_i,
  input  logic [DATA_W-1:0][WIDE_W-1:0] cols_i,
  output logic [DATA_W-1:0]             hit_o,
  output edac16_pkg::syn_class_e        class_o
);
  import edac16_pkg::*;

  for (genvar i = 0; i < DATA_W; i++) begin : g_hit
    assign hit_o[i] = (syn_i == cols_i[i]);
  end

  always_comb begin
    if (syn_i == '0)                 class_o = SYN_CLEAN;
    else if ($countones(syn_i) == 1) class_o = SYN_CHK_BIT;
    else if (|hit_o)                 class_o = SYN_DATA;
    else                             class_o = SYN_UNCORR;
  end
endmodule

// File: rtl/edac16_flow.sv
module edac16_flow #(
  parameter int DATA_W   = 16,
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 6
) (
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [WIDE_W-1:0] chk_gen_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [WIDE_W-1:0] rd_chk_i,
  input  logic              corr_en_i,
  input  logic              narrow_mode_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [WIDE_W-1:0] syndrome_o,
  output logic              cerr_n_o,
  output logic              ncerr_n_o
);
  import edac16_pkg::*;

  localparam int PAD_W = WIDE_W - NARROW_W;
  localparam logic [WIDE_W-1:0] NARROW_MASK = {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0][WIDE_W-1:0] cols;
  logic [WIDE_W-1:0]             rd_recalc;
  logic [WIDE_W-1:0]             width_mask;
  logic [WIDE_W-1:0]             syn;
  logic [DATA_W-1:0]             flip_mask;
  syn_class_e                    syn_class;

  // named events for the checker
  logic syn_zero, syn_chk_hit, syn_data_hit, syn_bad;

  edac16_col_rom #(.DATA_W(DATA_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_rom (
    .narrow_i (narrow_mode_i),
    .cols_o   (cols)
  );

  edac16_chk_gen #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_gen_wr (
    .data_i (wr_data_i),
    .cols_i (cols),
    .chk_o  (chk_gen_o)
  );

  edac16_chk_gen #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_gen_rd (
    .data_i (rd_data_i),
    .cols_i (cols),
    .chk_o  (rd_recalc)
  );

  assign width_mask = narrow_mode_i ? NARROW_MASK : '1;
  assign syn        = (rd_recalc ^ rd_chk_i) & width_mask;

  edac16_syn_decode #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_dec (
    .syn_i   (syn),
    .cols_i  (cols),
    .hit_o   (flip_mask),
    .class_o (syn_class)
  );

  assign syn_zero     = (syn_class == SYN_CLEAN);
  assign syn_chk_hit  = (syn_class == SYN_CHK_BIT);
  assign syn_data_hit = (syn_class == SYN_DATA);
  assign syn_bad      = (syn_class == SYN_UNCORR);

  assign syndrome_o = syn;
  assign rd_data_o  = rd_data_i ^ ((corr_en_i && syn_data_hit) ? flip_mask : '0);
  assign cerr_n_o   = !(syn_chk_hit || syn_data_hit);
  assign ncerr_n_o  = !syn_bad;
endmodule

// File: rtl/edac16_flow_chk.sv
module edac16_flow_chk #(
  parameter int DATA_W   = 16,
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 6
) (
  input logic [DATA_W-1:0] rd_data_i,
  input logic              corr_en_i,
  input logic              narrow_mode_i,
  input logic [WIDE_W-1:0] chk_gen_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [WIDE_W-1:0] syndrome_o,
  input logic              cerr_n_o,
  input logic              ncerr_n_o,
  input logic [DATA_W-1:0] flip_mask,
  input logic              syn_bad
);
  always_comb begin
    AST_QUIET_ON_ZERO: assert ((syndrome_o != '0) || (cerr_n_o && ncerr_n_o && rd_data_o == rd_data_i)); // R3
    AST_FLAGS_EXCLUSIVE: assert (cerr_n_o || ncerr_n_o); // R8
    AST_AT_MOST_ONE_FLIP: assert ($countones(rd_data_o ^ rd_data_i) <= 1); // R5
    AST_NO_FLIP_DISABLED: assert (corr_en_i || rd_data_o == rd_data_i); // R6
    AST_NO_FLIP_UNCORR: assert (ncerr_n_o || rd_data_o == rd_data_i); // R8
    AST_CHK_BIT_ONLY_FLAG: assert (($countones(syndrome_o) != 1) || (!cerr_n_o && ncerr_n_o && rd_data_o == rd_data_i)); // R7
    AST_BAD_MATCHES_NONE: assert (!syn_bad || flip_mask == '0); // R8
    AST_NARROW_TOP_ZERO: assert (!narrow_mode_i || (syndrome_o[WIDE_W-1:NARROW_W] == '0 && chk_gen_o[WIDE_W-1:NARROW_W] == '0)); // R2
  end
endmodule

bind edac16_flow edac16_flow_chk #(.DATA_W(DATA_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_flow_chk (
  .rd_data_i     (rd_data_i),
  .corr_en_i     (corr_en_i),
  .narrow_mode_i (narrow_mode_i),
  .chk_gen_o     (chk_gen_o),
  .rd_data_o     (rd_data_o),
  .syndrome_o    (syndrome_o),
  .cerr_n_o      (cerr_n_o),
  .ncerr_n_o     (ncerr_n_o),
  .flip_mask     (flip_mask),
  .syn_bad       (syn_bad)
);

// File: tb/edac16_flow_tb.sv
module edac16_flow_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int WW = 8;
  localparam int NW = 6;

  logic          clk = 1'b0;
  logic [DW-1:0] wr_data, rd_data, rd_out;
  logic [WW-1:0] chk_gen, rd_chk, syn;
  logic          corr_en, narrow, cerr_n, ncerr_n;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edac16_flow dut_i (
    .wr_data_i     (wr_data),
    .chk_gen_o     (chk_gen),
    .rd_data_i     (rd_data),
    .rd_chk_i      (rd_chk),
    .corr_en_i     (corr_en),
    .narrow_mode_i (narrow),
    .rd_data_o     (rd_out),
    .syndrome_o    (syn),
    .cerr_n_o      (cerr_n),
    .ncerr_n_o     (ncerr_n)
  );

  // columns listed by walking bit triples in ascending order
  function automatic logic [WW-1:0] ref_col(int idx, bit nar);
    int w, slot, cnt;
    logic [WW-1:0] res;
    w = nar ? NW : WW;
    slot = idx;
    if (nar && idx == 2) slot = 9;
    else if (nar && idx == 9) slot = 2;
    cnt = 0;
    res = '0;
    for (int c = 2; c < w; c++)
      for (int b = 1; b < c; b++)
        for (int a = 0; a < b; a++) begin
          if (cnt == slot) begin
            res = '0;
            res[a] = 1'b1; res[b] = 1'b1; res[c] = 1'b1;
          end
          cnt++;
        end
    return res;
  endfunction

  function automatic logic [WW-1:0] ref_gen(logic [DW-1:0] d, bit nar);
    logic [WW-1:0] r = '0;
    for (int i = 0; i < DW; i++) if (d[i]) r ^= ref_col(i, nar);
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive a read, then compare every output to the model
  task automatic read_vec(logic [DW-1:0] d, logic [WW-1:0] c, bit ce, bit nar, string tag);
    logic [WW-1:0] msk, esyn;
    logic [DW-1:0] eout;
    bit ecerr_n, encerr_n;
    int hit;
    @(negedge clk);
    rd_data = d; rd_chk = c; corr_en = ce; narrow = nar;
    #1;
    msk  = nar ? WW'((1 << NW) - 1) : '1;
    esyn = (ref_gen(d, nar) ^ c) & msk;
    hit  = -1;
    for (int i = 0; i < DW; i++) if (esyn == ref_col(i, nar)) hit = i;
    eout = d; ecerr_n = 1'b1; encerr_n = 1'b1;
    if (esyn == '0) begin
    end else if ($countones(esyn) == 1) ecerr_n = 1'b0;
    else if (hit >= 0) begin
      ecerr_n = 1'b0;
      if (ce) eout[hit] = ~eout[hit];
    end else encerr_n = 1'b0;
    check(syn == esyn, {tag, " syndrome"}, 32'(syn), 32'(esyn));
    check(rd_out == eout, {tag, " data"}, 32'(rd_out), 32'(eout));
    check({cerr_n, ncerr_n} == {ecerr_n, encerr_n}, {tag, " flags"},
          32'({cerr_n, ncerr_n}), 32'({ecerr_n, encerr_n}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [WW-1:0] c;
    int p, q;
    void'($urandom(32'h5EC0DED1));
    wr_data = '0; rd_data = '0; rd_chk = '0; corr_en = 1'b0; narrow = 1'b0;
    #1;
    // idle state: all-zero inputs
    check(chk_gen == '0 && cerr_n && ncerr_n, "R3 idle", 32'({chk_gen, cerr_n, ncerr_n}), 32'h3);

    // R9: pinned column in narrow mode
    read_vec(16'h0004, '0, 1'b1, 1'b1, "R9 bit2 narrow");
    check(syn == 8'h1C, "R9 syndrome value", 32'(syn), 32'h1C);

    // R11: mid-cycle change settles with no edge
    @(posedge clk); #2;
    narrow = 1'b0; corr_en = 1'b1; rd_data = 16'h8001; rd_chk = ref_gen(16'h8000, 1'b0);
    #1;
    check(rd_out == 16'h8000 && !cerr_n, "R11 no-edge settle", 32'(rd_out), 32'h8000);

    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 20; n++) begin
        d = 16'($urandom);
        if (n == 0) d = '0;
        if (n == 1) d = '1;
        @(negedge clk);
        wr_data = d; narrow = m[0];
        #1;
        check(chk_gen == ref_gen(d, m[0]), "R1 R2 generate", 32'(chk_gen), 32'(ref_gen(d, m[0])));
        c = chk_gen;
        read_vec(d, c, 1'($urandom), m[0], "R3 clean");
        for (int i = 0; i < DW; i++)
          read_vec(d ^ (DW'(1) << i), c, 1'($urandom), m[0], "R4 R5 R6 data single");
        for (int k = 0; k < (m ? NW : WW); k++)
          read_vec(d, c ^ (WW'(1) << k), 1'b1, m[0], "R7 check single");
        if (m == 1)
          read_vec(d, c ^ {2'($urandom), 6'h0}, 1'b1, 1'b1, "R10 unused lines");
        for (int t = 0; t < 6; t++) begin
          logic [DW+WW-1:0] e;
          p = int'($urandom_range(DW + (m ? NW : WW) - 1));
          q = (p + 1 + int'($urandom_range(DW + (m ? NW : WW) - 2))) % (DW + (m ? NW : WW));
          e = '0; e[p] = 1'b1;
          e[q] = 1'b1;
          if (m == 1) e = {e[DW+NW-1:DW] << 0, e[DW-1:0]} & {{(WW-NW){1'b0}}, {(DW+NW){1'b1}}};
          read_vec(d ^ e[DW-1:0], c ^ e[DW+WW-1:DW], 1'b1, m[0], "R8 double");
        end
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule